// File: doc/BRIEF.md
# Endian-Selectable Half-Word Bridge

This block moves data between a 36-bit wide stream and an 18-bit narrow stream in both directions, on a single clock. On the downsizing path every wide word is taken in once and handed out as two narrow words over two narrow transfers. On the upsizing path two consecutive narrow words are collected and delivered as one wide word. Every one of the four stream edges uses a valid/ready handshake.

The order of the two halves comes from a single select input. The block samples that input on every clock edge while reset is held low and keeps the captured value until the next reset. The captured setting governs both paths. With the select high, the upper half (bits 35:18) is the first narrow word. With the select low, the lower half (bits 17:0) is first.

Top module: `width_bridge`

## Requirements
- R1: The half order is captured from `big_endian_i` on clock edges while `rst_n` is low. Changes on `big_endian_i` while `rst_n` is high change neither path's ordering.
- R2: When the select was captured high, the first narrow word given out for a wide word is bits 35:18 and the second is bits 17:0.
- R3: When the select was captured low, the first narrow word given out for a wide word is bits 17:0 and the second is bits 35:18.
- R4: When the select was captured high, the first narrow word received is placed in bits 35:18 of the packed wide word and the second in bits 17:0.
- R5: When the select was captured low, the first narrow word received is placed in bits 17:0 of the packed wide word and the second in bits 35:18.
- R6: A wide word accepted on a clock edge drives `n_out_valid` high from that edge on. `w_in_ready` stays low while the first half of the held word is undelivered. It can be high in the same cycle that the second half is taken.
- R7: `w_out_valid` only rises on the edge that accepts the second narrow word of a pair. It never shows a word that has fewer than two collected halves.
- R8: While reset is low, `n_out_valid` and `w_out_valid` are low and both input readies are high. A narrow word collected before reset is discarded, so the first pair after reset forms the first packed word.
- R9: While an output is valid and its ready is low, that output stays valid and its data does not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released on a clock-synchronous edge |
| big_endian_i | input | 1 | Half-order select, sampled while reset is low (1 = upper half first) |
| w_in_valid | input | 1 | Wide input word is valid |
| w_in_ready | output | 1 | Downsizer can take a wide word |
| w_in_data | input | 36 | Wide input word |
| n_out_valid | output | 1 | Narrow output word is valid |
| n_out_ready | input | 1 | Narrow sink takes the word |
| n_out_data | output | 18 | Narrow output word |
| n_in_valid | input | 1 | Narrow input word is valid |
| n_in_ready | output | 1 | Upsizer can take a narrow word |
| n_in_data | input | 18 | Narrow input word |
| w_out_valid | output | 1 | Packed wide word is valid |
| w_out_ready | input | 1 | Wide sink takes the word |
| w_out_data | output | 36 | Packed wide word |

## Verification
The assertions take for granted that the sources obey the handshake: a valid, once raised, stays up with unchanged data until ready is seen. They also assume that the clock keeps running while reset is low, so that the select can be captured. The bench draws valids, readies, data and the select from a fixed-seed random stream. A source that sees no ready keeps its valid and data, so the stimulus stays inside these assumptions. The select is toggled only in ways that R1 says must not matter. Directed sequences cover a reset that arrives with a half collected, and they cover draining under full readiness.

// File: rtl/width_bridge_pkg.sv
package width_bridge_pkg;

  typedef enum logic {
    ORDER_LOW_FIRST  = 1'b0,
    ORDER_HIGH_FIRST = 1'b1
  } half_order_e;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } half_phase_e;

endpackage

// File: rtl/wb_order_latch.sv
module wb_order_latch
  import width_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_i,
  output half_order_e order_o
);

  half_order_e order_q;
  half_order_e order_d;

  always_comb begin
    order_d = order_q;
    if (!rst_n) begin
      order_d = half_order_e'(sel_i);
    end
  end

  always_ff @(posedge clk) begin
    order_q <= order_d;
  end

  assign order_o = order_q;

  // R1
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(order_q));

endmodule

// File: rtl/wb_unpacker.sv
module wb_unpacker
  import width_bridge_pkg::*;
#(
  parameter int NARROW_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  half_order_e           order_i,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*NARROW_W-1:0] in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [NARROW_W-1:0]   out_data
);

  localparam int WIDE_W = 2 * NARROW_W;

  logic [WIDE_W-1:0] word_q;
  logic              valid_q, valid_d;
  half_phase_e       phase_q, phase_d;
  logic              take_out, last_take, load;
  logic [NARROW_W-1:0] upper_half, lower_half;

  always_comb begin
    take_out  = valid_q && out_ready;
    last_take = take_out && (phase_q == PH_SECOND);
    in_ready  = !valid_q || last_take;
    load      = in_valid && in_ready;

    valid_d = valid_q;
    phase_d = phase_q;
    if (load) begin
      valid_d = 1'b1;
      phase_d = PH_FIRST;
    end else if (last_take) begin
      valid_d = 1'b0;
      phase_d = PH_FIRST;
    end else if (take_out) begin
      phase_d = PH_SECOND;
    end
  end

  always_comb begin
    upper_half = word_q[WIDE_W-1:NARROW_W];
    lower_half = word_q[NARROW_W-1:0];
    if ((phase_q == PH_FIRST) == (order_i == ORDER_HIGH_FIRST)) begin
      out_data = upper_half;
    end else begin
      out_data = lower_half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      phase_q <= PH_FIRST;
    end else begin
      valid_q <= valid_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      word_q <= in_data;
    end
  end

  assign out_valid = valid_q;

  // R6
  unpack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && phase_q == PH_FIRST));

  // R6
  unpack_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && phase_q == PH_FIRST) |-> !in_ready);

  // R9
  unpack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/wb_packer.sv
module wb_packer
  import width_bridge_pkg::*;
#(
  parameter int NARROW_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  half_order_e           order_i,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NARROW_W-1:0]   in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*NARROW_W-1:0] out_data
);

  localparam int WIDE_W = 2 * NARROW_W;

  logic [NARROW_W-1:0] half_q;
  logic [WIDE_W-1:0]   word_q, packed_word;
  logic                ovalid_q, ovalid_d;
  half_phase_e         phase_q, phase_d;
  logic                accept, cap_first, complete, take;

  always_comb begin
    take      = ovalid_q && out_ready;
    in_ready  = (phase_q == PH_FIRST) || !ovalid_q || out_ready;
    accept    = in_valid && in_ready;
    cap_first = accept && (phase_q == PH_FIRST);
    complete  = accept && (phase_q == PH_SECOND);

    phase_d = phase_q;
    if (accept) begin
      phase_d = (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end

    ovalid_d = ovalid_q;
    if (complete) begin
      ovalid_d = 1'b1;
    end else if (take) begin
      ovalid_d = 1'b0;
    end

    if (order_i == ORDER_HIGH_FIRST) begin
      packed_word = {half_q, in_data};
    end else begin
      packed_word = {in_data, half_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovalid_q <= 1'b0;
      phase_q  <= PH_FIRST;
    end else begin
      ovalid_q <= ovalid_d;
      phase_q  <= phase_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_first) begin
      half_q <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (complete) begin
      word_q <= packed_word;
    end
  end

  assign out_valid = ovalid_q;
  assign out_data  = word_q;

  // R7
  pack_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && phase_q == PH_SECOND));

  // R7
  pack_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (phase_q != $past(phase_q)));

  // R9
  pack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/width_bridge.sv
module width_bridge
  import width_bridge_pkg::*;
#(
  parameter int NARROW_W = 18,
  localparam int WIDE_W = 2 * NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian_i,
  input  logic              w_in_valid,
  output logic              w_in_ready,
  input  logic [WIDE_W-1:0] w_in_data,
  output logic              n_out_valid,
  input  logic              n_out_ready,
  output logic [NARROW_W-1:0] n_out_data,
  input  logic              n_in_valid,
  output logic              n_in_ready,
  input  logic [NARROW_W-1:0] n_in_data,
  output logic              w_out_valid,
  input  logic              w_out_ready,
  output logic [WIDE_W-1:0] w_out_data
);

  half_order_e order;

  wb_order_latch order_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (big_endian_i),
    .order_o (order)
  );

  wb_unpacker #(.NARROW_W(NARROW_W)) down_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_i   (order),
    .in_valid  (w_in_valid),
    .in_ready  (w_in_ready),
    .in_data   (w_in_data),
    .out_valid (n_out_valid),
    .out_ready (n_out_ready),
    .out_data  (n_out_data)
  );

  wb_packer #(.NARROW_W(NARROW_W)) up_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_i   (order),
    .in_valid  (n_in_valid),
    .in_ready  (n_in_ready),
    .in_data   (n_in_data),
    .out_valid (w_out_valid),
    .out_ready (w_out_ready),
    .out_data  (w_out_data)
  );

endmodule

// File: tb/width_bridge_tb_top.sv
`timescale 1ns/1ps
module width_bridge_tb_top;

  localparam int NW = 18;
  localparam int WW = 2 * NW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          big_endian_i;
  logic          w_in_valid;
  logic          w_in_ready;
  logic [WW-1:0] w_in_data;
  logic          n_out_valid;
  logic          n_out_ready;
  logic [NW-1:0] n_out_data;
  logic          n_in_valid;
  logic          n_in_ready;
  logic [NW-1:0] n_in_data;
  logic          w_out_valid;
  logic          w_out_ready;
  logic [WW-1:0] w_out_data;

  int errors = 0;
  int checks = 0;

  logic [NW-1:0] exp_n[$];
  logic [WW-1:0] exp_w[$];
  logic          have_first;
  logic [NW-1:0] first_half;

  always #4 clk = ~clk;

  width_bridge #(.NARROW_W(NW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .big_endian_i (big_endian_i),
    .w_in_valid   (w_in_valid),
    .w_in_ready   (w_in_ready),
    .w_in_data    (w_in_data),
    .n_out_valid  (n_out_valid),
    .n_out_ready  (n_out_ready),
    .n_out_data   (n_out_data),
    .n_in_valid   (n_in_valid),
    .n_in_ready   (n_in_ready),
    .n_in_data    (n_in_data),
    .w_out_valid  (w_out_valid),
    .w_out_ready  (w_out_ready),
    .w_out_data   (w_out_data)
  );

  task automatic check(input bit ok, input string req,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] half_at(input logic [WW-1:0] w, input bit big, input bit second);
    if (big ^ second) return w[WW-1:NW];
    return w[NW-1:0];
  endfunction

  function automatic logic [WW-1:0] pack_pair(input logic [NW-1:0] a, input logic [NW-1:0] b, input bit big);
    if (big) return {a, b};
    return {b, a};
  endfunction

  task automatic do_reset(input bit big);
    @(negedge clk);
    rst_n = 1'b0;
    big_endian_i = big;
    w_in_valid = 1'b0;
    n_in_valid = 1'b0;
    n_out_ready = 1'b0;
    w_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R8
    check(!n_out_valid, "R8 n_out_valid", WW'(n_out_valid), '0);
    check(!w_out_valid, "R8 w_out_valid", WW'(w_out_valid), '0);
    check(w_in_ready, "R8 w_in_ready", WW'(w_in_ready), WW'(1));
    check(n_in_ready, "R8 n_in_ready", WW'(n_in_ready), WW'(1));
    rst_n = 1'b1;
    exp_n.delete();
    exp_w.delete();
    have_first = 1'b0;
  endtask

  task automatic run_traffic(input int cycles, input bit toggle_sel, input bit big, input bit quiet);
    bit w_hold = 1'b0;
    bit n_hold = 1'b0;
    bit nbp = 1'b0;
    bit wbp = 1'b0;
    logic [NW-1:0] prev_nd = '0;
    logic [WW-1:0] prev_wd = '0;
    logic [NW-1:0] got_n;
    logic [WW-1:0] got_w;
    string tag_n = big ? "R2" : "R3";
    string tag_w = big ? "R4" : "R5";
    if (toggle_sel) begin
      tag_n = {"R1 ", tag_n};
      tag_w = {"R1 ", tag_w};
    end
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (!w_hold) begin
        w_in_valid = quiet ? 1'b0 : ($urandom % 4 != 0);
        w_in_data  = {4'($urandom), 32'($urandom)};
      end
      if (!n_hold) begin
        n_in_valid = quiet ? 1'b0 : ($urandom % 4 != 0);
        n_in_data  = 18'($urandom);
      end
      n_out_ready = quiet ? 1'b1 : ($urandom % 3 != 0);
      w_out_ready = quiet ? 1'b1 : ($urandom % 3 != 0);
      if (toggle_sel) big_endian_i = 1'($urandom);
      #1;
      // R6: first half still pending blocks the wide input
      if (exp_n.size() >= 2) check(!w_in_ready, "R6 w_in_ready", WW'(w_in_ready), '0);
      if (exp_n.size() == 0) check(!n_out_valid, "R6 n_out_valid", WW'(n_out_valid), '0);
      else check(n_out_valid, "R6 n_out_valid", WW'(n_out_valid), WW'(1));
      // R7: no packed word before a full pair
      if (exp_w.size() == 0) check(!w_out_valid, "R7 w_out_valid", WW'(w_out_valid), '0);
      // R9
      if (nbp) check(n_out_valid && n_out_data == prev_nd, "R9 n_out_data", WW'(n_out_data), WW'(prev_nd));
      if (wbp) check(w_out_valid && w_out_data == prev_wd, "R9 w_out_data", w_out_data, prev_wd);

      if (n_out_valid && n_out_ready) begin
        if (exp_n.size() == 0) check(1'b0, "R6 spurious narrow", WW'(n_out_data), '0);
        else begin
          got_n = exp_n.pop_front();
          check(n_out_data == got_n, tag_n, WW'(n_out_data), WW'(got_n));
        end
      end
      if (w_in_valid && w_in_ready) begin
        exp_n.push_back(half_at(w_in_data, big, 1'b0));
        exp_n.push_back(half_at(w_in_data, big, 1'b1));
        w_hold = 1'b0;
      end else begin
        w_hold = w_in_valid;
      end
      if (w_out_valid && w_out_ready) begin
        if (exp_w.size() == 0) check(1'b0, "R7 spurious wide", w_out_data, '0);
        else begin
          got_w = exp_w.pop_front();
          check(w_out_data == got_w, tag_w, w_out_data, got_w);
        end
      end
      if (n_in_valid && n_in_ready) begin
        if (have_first) begin
          exp_w.push_back(pack_pair(first_half, n_in_data, big));
          have_first = 1'b0;
        end else begin
          first_half = n_in_data;
          have_first = 1'b1;
        end
        n_hold = 1'b0;
      end else begin
        n_hold = n_in_valid;
      end
      nbp = n_out_valid && !n_out_ready;
      wbp = w_out_valid && !w_out_ready;
      prev_nd = n_out_data;
      prev_wd = w_out_data;
    end
  endtask

  task automatic directed_pair(input logic [NW-1:0] a, input logic [NW-1:0] b,
                               input bit big, input string req);
    logic [WW-1:0] e;
    e = pack_pair(a, b, big);
    w_out_ready = 1'b0;
    @(negedge clk); n_in_valid = 1'b1; n_in_data = a;
    @(negedge clk); n_in_data = b;
    @(negedge clk); n_in_valid = 1'b0;
    #1;
    check(w_out_valid && w_out_data == e, req, w_out_data, e);
    w_out_ready = 1'b1;
    @(negedge clk); w_out_ready = 1'b0;
  endtask

  task automatic directed_split(input logic [WW-1:0] w, input bit big, input string req);
    n_out_ready = 1'b1;
    @(negedge clk); w_in_valid = 1'b1; w_in_data = w;
    @(negedge clk); w_in_valid = 1'b0;
    #1;
    check(n_out_valid && n_out_data == half_at(w, big, 1'b0), req, WW'(n_out_data), WW'(half_at(w, big, 1'b0)));
    @(negedge clk);
    #1;
    check(n_out_valid && n_out_data == half_at(w, big, 1'b1), req, WW'(n_out_data), WW'(half_at(w, big, 1'b1)));
    @(negedge clk);
    #1;
    check(!n_out_valid, "R6 drained", WW'(n_out_valid), '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    big_endian_i = 1'b1;
    w_in_valid = 1'b0; w_in_data = '0;
    n_in_valid = 1'b0; n_in_data = '0;
    n_out_ready = 1'b0; w_out_ready = 1'b0;
    have_first = 1'b0; first_half = '0;

    do_reset(1'b1);
    directed_split(36'h9_ABCD_1234, 1'b1, "R2 directed");
    directed_pair(18'h2_AAAA, 18'h1_5555, 1'b1, "R4 directed");
    run_traffic(2000, 1'b0, 1'b1, 1'b0);
    run_traffic(20, 1'b0, 1'b1, 1'b1);

    // R8: half collected, then reset discards it
    @(negedge clk); n_in_valid = 1'b1; n_in_data = 18'h3_0F0F;
    @(negedge clk); n_in_valid = 1'b0;
    do_reset(1'b0);
    directed_pair(18'h0_1111, 18'h3_2222, 1'b0, "R8 R5 discard");
    directed_split(36'h7_0123_4567, 1'b0, "R3 directed");

    // R1: select toggles after reset must not matter
    run_traffic(2000, 1'b1, 1'b0, 1'b0);
    run_traffic(20, 1'b1, 1'b0, 1'b1);
    do_reset(1'b1);
    run_traffic(2000, 1'b1, 1'b1, 1'b0);
    run_traffic(20, 1'b0, 1'b1, 1'b1);
    check(exp_n.size() == 0, "R6 narrow drain", WW'(exp_n.size()), '0);
    check(exp_w.size() == 0, "R7 wide drain", WW'(exp_w.size()), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule